// File: doc/BRIEF.md
# Dual-Clock Recentering Elastic FIFO

This block moves a continuous stream of 4-bit words from a write clock domain into a read clock domain. The two clocks run at the same nominal rate. Between them there may be a fixed phase offset and a slow, bounded drift. A word is stored on every write-clock edge and a word is delivered on every read-clock edge. The stream has no valid/ready handshake and no back-pressure: neither side can stall the other. All elasticity comes from the eight-entry store and the spacing kept between the two pointers.

Each side owns a pointer and passes it across to the other side in Gray code through a chain of synchronizer flops. When the block is recentered, the write pointer is set half the depth (four words) ahead of the read pointer. This leaves equal room for drift in either direction. If that room is used up, the block drives an active-low error flag. The flag stays low until the next recenter.

A recenter starts on any of three events: the global reset, an active-low recenter request, or a rising edge of the lock indicator. A recenter holds both pointers at their centred values for a short settling window. During that window the read data is forced to zero. Because the error flag and the recenter request share the same polarity, the flag can be wired straight back to the request so that the block recovers by itself.

Top module: `elastic_recenter_fifo`

## Requirements
- R1: While rst_n is low, rd_data is 0 and err_n is 1. After rst_n is released, the first DEPTH/2 read edges return words not yet defined by the stream.
- R2: With both clocks running, the n-th read edge after a recenter returns the word taken at the (n-4)-th write edge after that recenter. Words come out in the order they went in.
- R3: If the write clock loses up to three cycles relative to the read clock, err_n stays 1 and no word is lost or repeated.
- R4: If the read clock loses up to three cycles relative to the write clock, err_n stays 1 and no word is lost or repeated.
- R5: If the write clock loses four cycles (underflow), err_n goes to 0.
- R6: If the read clock loses four cycles (overflow), err_n goes to 0.
- R7: Once err_n is 0, it stays 0 until a recenter. After that recenter it returns to 1.
- R8: recenter_n is sampled through a two-flop synchronizer in each domain. While it is low, and for three further edges after it is seen high again, rd_data is 0 and both pointers are held centred.
- R9: A 0-to-1 transition of lock starts one recenter of the same length as R8. Keeping lock high, or dropping it, starts no further recenter.
- R10: When err_n is wired to recenter_n, an overflow or underflow is followed by an automatic recovery. After recovery, err_n is 1 and the R2 ordering holds again.
- R11: Words presented on write edges that fall inside a recenter window are dropped. The write pointer restarts at DEPTH/2 when the window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Global asynchronous reset, active low; also recenters |
| lock | input | 1 | Lock indicator; a rising edge requests a recenter |
| recenter_n | input | 1 | Recenter request, active low, asynchronous to both clocks |
| wr_clk | input | 1 | Write-side clock |
| wr_data | input | WIDTH | Word taken on every write-clock rising edge |
| rd_clk | input | 1 | Read-side clock; also paces the downstream consumer |
| rd_data | output | WIDTH | Word delivered on every read-clock rising edge; 0 while recentering |
| err_n | output | 1 | Overflow/underflow flag, active low, read-clock domain, sticky |

## Verification
The assertions assume that both clocks have the same nominal period. They also assume that a recenter window on one side overlaps the window on the other, so that neither pointer starts running while the other side still holds it centred.

The bench drives both clocks from one 125 MHz source. Each clock is gated off only for whole cycles while that source is low. This creates drift of an exact number of words while keeping the two sides edge-aligned otherwise. Every input changes on the falling edge.

// File: rtl/elastic_fifo_pkg.sv
package elastic_fifo_pkg;

  parameter int EF_SYNC_MIN = 2;

  // binary to reflected-binary code
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // reflected-binary code back to binary
  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/ef_sync.sv
module ef_sync #(
  parameter int             W      = 1,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   RST    = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= {STAGES{RST}};
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/ef_recenter.sv
module ef_recenter #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD        = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic recenter_n,
  input  logic lock,
  output logic busy
);
  localparam int CW = $clog2(HOLD + 1);

  logic          rc_s, lk_s, lk_d, trig;
  logic [CW-1:0] cnt;

  ef_sync #(.W(1), .STAGES(SYNC_STAGES), .RST(1'b1)) u_rc_sync (
    .clk(clk), .rst_n(rst_n), .d(recenter_n), .q(rc_s));

  ef_sync #(.W(1), .STAGES(SYNC_STAGES), .RST(1'b0)) u_lk_sync (
    .clk(clk), .rst_n(rst_n), .d(lock), .q(lk_s));

  assign trig = ~rc_s | (lk_s & ~lk_d);
  assign busy = trig | (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_d <= 1'b0;
      cnt  <= '0;
    end else begin
      lk_d <= lk_s;
      if (trig)             cnt <= CW'(HOLD);
      else if (cnt != '0)   cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/elastic_recenter_fifo.sv
module elastic_recenter_fifo
  import elastic_fifo_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int DEPTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             rst_n,
  input  logic             lock,
  input  logic             recenter_n,
  input  logic             wr_clk,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_clk,
  output logic [WIDTH-1:0] rd_data,
  output logic             err_n
);
  localparam int AW     = $clog2(DEPTH);
  localparam int PW     = AW + 2;
  localparam int CENTER = DEPTH / 2;
  localparam int HOLD   = SYNC_STAGES + 1;
  localparam logic [PW-1:0] W_INIT  = PW'(CENTER);
  localparam logic [PW-1:0] WG_INIT = PW'(to_gray(32'(CENTER)));
  // distances seen through the synchronizer lag
  localparam logic signed [PW-1:0] OF_VIEW = PW'(DEPTH + SYNC_STAGES);
  localparam logic signed [PW-1:0] UF_VIEW = PW'(-SYNC_STAGES);

  logic [WIDTH-1:0] mem [DEPTH];

  // ---------------- write domain ----------------
  logic                 wr_busy, wflag;
  logic [PW-1:0]        wptr, wgray, rgray_s, rsync_bin, wptr_inc;
  logic signed [PW-1:0] wview;

  ef_recenter #(.SYNC_STAGES(SYNC_STAGES), .HOLD(HOLD)) u_wr_ctl (
    .clk(wr_clk), .rst_n(rst_n), .recenter_n(recenter_n), .lock(lock),
    .busy(wr_busy));

  ef_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST('0)) u_rptr_sync (
    .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

  assign rsync_bin = PW'(from_gray(32'(rgray_s)));
  assign wview     = wptr - rsync_bin;
  assign wptr_inc  = wptr + 1'b1;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= W_INIT;
      wgray <= WG_INIT;
      wflag <= 1'b0;
    end else if (wr_busy) begin
      wptr  <= W_INIT;
      wgray <= WG_INIT;
      wflag <= 1'b0;
    end else begin
      wptr  <= wptr_inc;
      wgray <= PW'(to_gray(32'(wptr_inc)));
      if (wview >= OF_VIEW) wflag <= 1'b1;
    end
  end

  always_ff @(posedge wr_clk) begin
    if (!wr_busy) mem[wptr[AW-1:0]] <= wr_data;
  end

  // ---------------- read domain ----------------
  logic                 rd_busy, rflag, wflag_s;
  logic [PW-1:0]        rptr, rgray, wgray_s, wsync_bin, rptr_inc;
  logic signed [PW-1:0] rview;

  ef_recenter #(.SYNC_STAGES(SYNC_STAGES), .HOLD(HOLD)) u_rd_ctl (
    .clk(rd_clk), .rst_n(rst_n), .recenter_n(recenter_n), .lock(lock),
    .busy(rd_busy));

  ef_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST(WG_INIT)) u_wptr_sync (
    .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s));

  ef_sync #(.W(1), .STAGES(SYNC_STAGES), .RST(1'b0)) u_wflag_sync (
    .clk(rd_clk), .rst_n(rst_n), .d(wflag), .q(wflag_s));

  assign wsync_bin = PW'(from_gray(32'(wgray_s)));
  assign rview     = wsync_bin - rptr;
  assign rptr_inc  = rptr + 1'b1;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr    <= '0;
      rgray   <= '0;
      rflag   <= 1'b0;
      rd_data <= '0;
      err_n   <= 1'b1;
    end else begin
      err_n <= ~(rflag | wflag_s);
      if (rd_busy) begin
        rptr    <= '0;
        rgray   <= '0;
        rflag   <= 1'b0;
        rd_data <= '0;
      end else begin
        rptr    <= rptr_inc;
        rgray   <= PW'(to_gray(32'(rptr_inc)));
        rd_data <= mem[rptr[AW-1:0]];
        if (rview <= UF_VIEW) rflag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/elastic_recenter_fifo_chk.sv
module elastic_recenter_fifo_chk #(
  parameter int WIDTH  = 4,
  parameter int PW     = 5,
  parameter int CENTER = 4
) (
  input logic             wr_clk,
  input logic             rd_clk,
  input logic             rst_n,
  input logic             wr_busy,
  input logic             rd_busy,
  input logic [PW-1:0]    wptr,
  input logic [PW-1:0]    rptr,
  input logic [PW-1:0]    wgray,
  input logic [WIDTH-1:0] rd_data,
  input logic             err_n
);
  // R1
  always @(posedge rd_clk) begin
    if (!rst_n) rst_state_chk: assert (rd_data == '0 && err_n == 1'b1);
  end

  // R2
  rd_step_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_busy |=> rptr == PW'($past(rptr) + 1'b1));

  // R2
  wr_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_busy |=> wptr == PW'($past(wptr) + 1'b1));

  // R8
  rd_zero_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_busy |=> rd_data == '0);

  // R11
  wr_hold_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_busy |=> wptr == PW'(CENTER));

  // R3
  gray_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_busy |=> $countones(wgray ^ $past(wgray)) == 1);
endmodule

bind elastic_recenter_fifo elastic_recenter_fifo_chk #(
  .WIDTH(WIDTH), .PW(PW), .CENTER(CENTER)) u_chk (.*);

// File: tb/elastic_recenter_fifo_tb.sv
`timescale 1ns/1ps
module elastic_recenter_fifo_tb;
  localparam int HOLD = 3;
  localparam int LAT  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic w_run = 1'b1, r_run = 1'b1;
  logic lock = 1'b0, rc_drv = 1'b1, loop_en = 1'b0;
  logic [3:0] wr_data = '0;
  logic [3:0] rd_data;
  logic err_n;
  wire  wr_clk = clk & w_run;
  wire  rd_clk = clk & r_run;
  wire  recenter_n = loop_en ? err_n : rc_drv;

  elastic_recenter_fifo u_dut (
    .rst_n(rst_n), .lock(lock), .recenter_n(recenter_n),
    .wr_clk(wr_clk), .wr_data(wr_data), .rd_clk(rd_clk),
    .rd_data(rd_data), .err_n(err_n));

  always #4 clk = ~clk;

  int    vectors = 0, fails = 0, cycles = 0, pat = 0, cnt = 0;
  string tag = "R1";
  bit    chk_err = 1'b1, done = 1'b0;

  // behavioural reference
  logic [3:0] wlog[$];
  int  rcount = 0;
  bit  exp_valid = 1'b0;
  logic [3:0] exp_data = '0;
  bit  rs1 = 1, rs2 = 1, rl1 = 0, rl2 = 0, rl3 = 0;
  bit  ws1 = 1, ws2 = 1, wl1 = 0, wl2 = 0, wl3 = 0;
  int  rhold = 0, whold = 0;

  always @(posedge clk or negedge rst_n) begin
    bit trig, busy;
    int sz, idx;
    if (!rst_n) begin
      rs1 = 1; rs2 = 1; rl1 = 0; rl2 = 0; rl3 = 0; rhold = 0;
      ws1 = 1; ws2 = 1; wl1 = 0; wl2 = 0; wl3 = 0; whold = 0;
      wlog.delete(); rcount = 0; exp_valid = 1; exp_data = '0;
    end else begin
      sz = wlog.size();
      if (r_run) begin
        trig = !rs2 || (rl2 && !rl3);
        busy = trig || (rhold != 0);
        rhold = trig ? HOLD : (rhold != 0 ? rhold - 1 : 0);
        rs2 = rs1; rs1 = recenter_n; rl3 = rl2; rl2 = rl1; rl1 = lock;
        if (busy) begin
          exp_valid = 1; exp_data = '0; rcount = 0;
        end else begin
          idx = rcount - LAT;
          exp_valid = (idx >= 0) && (idx < sz) && (sz <= rcount + LAT);
          if (exp_valid) exp_data = wlog[idx];
          rcount++;
        end
      end
      if (w_run) begin
        trig = !ws2 || (wl2 && !wl3);
        busy = trig || (whold != 0);
        whold = trig ? HOLD : (whold != 0 ? whold - 1 : 0);
        ws2 = ws1; ws1 = recenter_n; wl3 = wl2; wl2 = wl1; wl1 = lock;
        if (busy) wlog.delete();
        else      wlog.push_back(wr_data);
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (exp_valid) begin
      vectors++;
      if (rd_data !== exp_data) begin
        fails++;
        $display("FAIL %s rd_data actual=%h expected=%h t=%0t", tag, rd_data, exp_data, $time);
      end
    end
    if (chk_err) begin
      vectors++;
      if (err_n !== 1'b1) begin
        fails++;
        $display("FAIL %s err_n actual=%b expected=1 t=%0t", tag, err_n, $time);
      end
    end
    if (cycles > 50000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  task automatic tick(int n);
    repeat (n) begin
      @(negedge clk);
      case (pat)
        0: wr_data = 4'($urandom);
        1: begin wr_data = 4'(cnt); cnt++; end
        default: wr_data = wr_data == 4'hF ? 4'h0 : 4'hF;
      endcase
    end
  endtask

  task automatic check_err(string t, logic exp);
    vectors++;
    if (err_n !== exp) begin
      fails++;
      $display("FAIL %s err_n actual=%b expected=%b", t, err_n, exp);
    end
  endtask

  task automatic recenter(int n);
    rc_drv = 1'b0; tick(n); rc_drv = 1'b1;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    tick(5);
    // R1: reset state
    vectors++;
    if (rd_data !== 4'h0 || err_n !== 1'b1) begin
      fails++;
      $display("FAIL R1 actual=%h/%b expected=0/1", rd_data, err_n);
    end
    rst_n = 1'b1;
    tag = "R2"; tick(60);
    pat = 1; tick(40);
    pat = 2; tick(20);
    pat = 0;
    // R3: write clock drops three cycles
    tag = "R3"; w_run = 1'b0; tick(3); w_run = 1'b1; tick(25);
    // R4: read clock drops three cycles
    tag = "R4"; r_run = 1'b0; tick(3); r_run = 1'b1; tick(25);
    // R8: external recenter
    tag = "R8"; recenter(3); tick(25);
    // R11: words inside the window are dropped (counting pattern)
    tag = "R11"; pat = 1; tick(5); recenter(2); tick(25); pat = 0;
    // R9: lock rise, then held high, then dropped
    tag = "R9"; lock = 1'b1; tick(40); lock = 1'b0; tick(20);
    // R5: underflow
    tag = "R5"; chk_err = 1'b0;
    w_run = 1'b0; tick(4); w_run = 1'b1; tick(8);
    check_err("R5", 1'b0);
    // R7: sticky until recenter
    tag = "R7"; tick(12); check_err("R7", 1'b0);
    recenter(2); tick(10); check_err("R7", 1'b1);
    chk_err = 1'b1; tick(20);
    // R6: overflow
    tag = "R6"; chk_err = 1'b0;
    r_run = 1'b0; tick(4); r_run = 1'b1; tick(8);
    check_err("R6", 1'b0);
    recenter(2); tick(10); check_err("R6", 1'b1);
    chk_err = 1'b1; tick(20);
    // R10: error looped to recenter
    tag = "R10"; chk_err = 1'b0; loop_en = 1'b1;
    w_run = 1'b0; tick(4); w_run = 1'b1; tick(40);
    check_err("R10", 1'b1);
    chk_err = 1'b1; pat = 1; tick(30);
    loop_en = 1'b0; pat = 0; tick(10);
    done = 1'b1;
    summary();
  end
endmodule